// File: doc/BRIEF.md
# Oversampling UART Receiver with Multidrop Wakeup

This block recovers asynchronous serial frames from a receive line sampled at sixteen times the bit rate. A frame is a low start bit, eight or nine frame bits sent least significant first, and a high stop bit. When parity is on, the last frame bit is the parity bit. The block reports each frame through a data register and a set of sticky flags: data ready, overrun, noise, framing error, parity error and idle line. Software clears these flags by pulsing strobe bits.

For multidrop networks the receiver can be put to sleep. While asleep, it quietly discards traffic. It wakes either on a frame whose last frame bit is 1 (an address frame), or on a newly detected idle line. The receive input can be taken from the pin, from the transmitter's internal output, or from the transmit pin, and it can be inverted.

The frame controller has four states:
- ST_WAIT: the line is idle and ones are counted.
- ST_START: the start bit is being validated.
- ST_DATA: frame bits are being collected.
- ST_STOP: the stop bit is being sampled.

Transitions, taken only on an oversampling tick while the receiver is enabled:
- ST_WAIT→ST_START on a 1-to-0 edge of the line.
- ST_START→ST_WAIT on a false start.
- ST_START→ST_DATA at the end of the start bit.
- ST_DATA→ST_STOP after the last frame bit.
- ST_STOP→ST_WAIT at the stop-bit vote.
- Any state→ST_WAIT when the receiver is disabled.

Top module: `uart_os_rx`

## Requirements
- R1: A frame's first 8 frame bits, least significant first, load `rx_data` and set `rdrf`. With `cfg_nine`=1 the ninth frame bit loads `rx_bit8`; with `cfg_nine`=0, `rx_bit8` loads 0.
- R2: `frame_err` is set when the stop-bit vote is 0.
- R3: If `rdrf` or `ovr` is set when a frame completes, `ovr` is set and `rx_data`/`rx_bit8` keep their old value.
- R4: `noise` is set together with `rdrf` when the three samples of any start, frame or stop bit disagree. It is never set by a frame that overruns.
- R5: With `cfg_par_en`=1, `par_err` is set when the count of ones over all frame bits (parity bit included) is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1.
- R6: `idle` is set once the run of high bit-times reaches 10 (11 when `cfg_nine`=1). With `cfg_idle_after_stop`=0 the run starts after the start bit. With `cfg_idle_after_stop`=1 it starts after the stop bit.
- R7: After `idle` has been set, it cannot be set again until a frame has loaded the data register.
- R8: While `rwu`=1, completed frames change no flag or data, `idle` is not set, and the data-ready/overrun interrupt is masked. `rwu_set` sets `rwu`.
- R9: With `cfg_wake_addr`=1, a frame whose last frame bit is 1 clears `rwu` and is received normally. With `cfg_wake_addr`=0, a newly detected idle line clears `rwu`.
- R10: Input source selection:
  - `cfg_loop`=1 ignores `rx_pin` and uses `tx_int` (`cfg_loop_pin`=0) or `tx_pin` (`cfg_loop_pin`=1).
  - `cfg_rx_inv`=1 inverts the selected input.
- R11: Each bit is the majority of oversamples 7, 8 and 9 of 16. A start bit whose majority is 1 is dropped with no flag change. `rx_active` is high while a frame is in progress.
- R12: `irq` = (`irq_rx_en` & !`rwu` & (`rdrf` | `ovr`)) | (`irq_idle_en` & `idle`).
- R13: A `clr_mask` pulse clears flags by bit position: bit0 `rdrf`, bit1 `ovr`, bit2 `noise`, bit3 `frame_err`, bit4 `par_err`, bit5 `idle`. With `cfg_rx_en`=0, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_pin | input | 1 | Receive pin |
| tx_int | input | 1 | Transmitter internal output |
| tx_pin | input | 1 | Transmit pin level |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_nine | input | 1 | Nine frame bits |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | 1 odd, 0 even parity |
| cfg_idle_after_stop | input | 1 | Idle run counted from stop bit |
| cfg_wake_addr | input | 1 | Wake on address frame (else idle) |
| cfg_rx_inv | input | 1 | Invert received signal |
| cfg_loop | input | 1 | Loopback enable |
| cfg_loop_pin | input | 1 | Loopback from transmit pin |
| rwu_set | input | 1 | Enter wakeup sleep |
| clr_mask | input | 6 | Flag clear strobes |
| irq_rx_en | input | 1 | Ready/overrun interrupt enable |
| irq_idle_en | input | 1 | Idle interrupt enable |
| rx_data | output | 8 | Received byte |
| rx_bit8 | output | 1 | Ninth received bit |
| rdrf | output | 1 | Data ready |
| ovr | output | 1 | Overrun |
| noise | output | 1 | Noise |
| frame_err | output | 1 | Framing error |
| par_err | output | 1 | Parity error |
| idle | output | 1 | Idle line |
| rwu | output | 1 | Receiver asleep |
| rx_active | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
A misaligned sub-bit counter or data index shows within one frame, as a wrong `rx_data` byte or a spurious `frame_err` at the stop bit. A wrong run-of-ones count or a stale idle arm shows within a dozen bit-times, as `idle` rising too early, too late or twice without an intervening load. A sleep bit that fails to clear shows on the next address frame or idle gap, because `rdrf` stays low.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    localparam int FRAME_MAX = 9;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic                 noisy;
        logic                 stop_ok;
    } rx_frame_t;
endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic tx_int,
    input  logic tx_pin,
    input  logic loop_en,
    input  logic loop_pin,
    input  logic invert,
    output logic line_q
);
    logic raw;

    always_comb begin
        if (loop_en) raw = loop_pin ? tx_pin : tx_int;
        else         raw = rx_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= raw ^ invert;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int RUN_W     = 4,
    parameter int IDLE_BASE = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      en,
    input  logic      line,
    input  logic      nine,
    input  logic      idle_after_stop,
    output logic      done,
    output rx_frame_t frame,
    output logic      active,
    output logic      idle_hit
);
    localparam int SUB_W = $clog2(OVS + 1);
    localparam int MID   = OVS / 2;
    localparam int IDX_W = $clog2(FRAME_MAX + 1);

    rx_state_e            state_q, state_d;
    logic [SUB_W-1:0]     sub_q;
    logic [SUB_W-1:0]     wcnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [RUN_W-1:0]     run_q;
    logic [FRAME_MAX-1:0] bits_q;
    logic                 prev_q, s_a, s_b, noisy_q, stop_q, done_q;

    logic                 vote, bit_noisy, at_vote, at_end, edge_seen;
    logic [IDX_W-1:0]     last_idx;
    logic [RUN_W-1:0]     run_inc, thr;

    assign vote      = (s_a & s_b) | (s_a & line) | (s_b & line);
    assign bit_noisy = !((s_a == s_b) && (s_b == line));
    assign at_vote   = (sub_q == SUB_W'(MID + 1));
    assign at_end    = (sub_q == SUB_W'(OVS));
    assign edge_seen = prev_q && !line;
    assign last_idx  = nine ? IDX_W'(FRAME_MAX - 1) : IDX_W'(FRAME_MAX - 2);
    assign run_inc   = (run_q == {RUN_W{1'b1}}) ? run_q : run_q + RUN_W'(1);
    assign thr       = nine ? RUN_W'(IDLE_BASE + 1) : RUN_W'(IDLE_BASE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_WAIT;
        end else if (tick) begin
            unique case (state_q)
                ST_WAIT:  if (edge_seen) state_d = ST_START;
                ST_START: begin
                    if (at_vote && vote) state_d = ST_WAIT;
                    else if (at_end)     state_d = ST_DATA;
                end
                ST_DATA:  if (at_end && idx_q == last_idx) state_d = ST_STOP;
                ST_STOP:  if (at_vote) state_d = ST_WAIT;
            endcase
        end
    end

    // sampling, counters and frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0; wcnt_q <= '0; idx_q <= '0; run_q <= '0; bits_q <= '0;
            prev_q <= 1'b0; s_a <= 1'b1; s_b <= 1'b1;
            noisy_q <= 1'b0; stop_q <= 1'b1; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                sub_q <= '0; wcnt_q <= '0; run_q <= '0; idx_q <= '0; prev_q <= 1'b0;
            end else if (tick) begin
                prev_q <= line;
                if (state_q == ST_WAIT) begin
                    if (edge_seen) begin
                        sub_q <= SUB_W'(1); run_q <= '0; wcnt_q <= '0;
                        idx_q <= '0; bits_q <= '0; noisy_q <= 1'b0;
                    end else if (line) begin
                        if (wcnt_q == SUB_W'(OVS - 1)) begin
                            wcnt_q <= '0;
                            run_q  <= run_inc;
                        end else begin
                            wcnt_q <= wcnt_q + SUB_W'(1);
                        end
                    end else begin
                        wcnt_q <= '0;
                        run_q  <= '0;
                    end
                end else begin
                    sub_q <= at_end ? SUB_W'(1) : sub_q + SUB_W'(1);
                    if (sub_q == SUB_W'(MID - 1)) s_a <= line;
                    if (sub_q == SUB_W'(MID))     s_b <= line;
                    if (at_vote) begin
                        if (state_q == ST_START) begin
                            noisy_q <= bit_noisy;
                            wcnt_q  <= '0;
                        end else if (state_q == ST_DATA) begin
                            bits_q[idx_q] <= vote;
                            noisy_q <= noisy_q | bit_noisy;
                            run_q   <= vote ? run_inc : '0;
                        end else begin
                            done_q  <= 1'b1;
                            stop_q  <= vote;
                            noisy_q <= noisy_q | bit_noisy;
                            run_q   <= (idle_after_stop || !vote) ? '0 : run_inc;
                            wcnt_q  <= '0;
                        end
                    end
                    if (at_end && state_q == ST_DATA) idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    assign done          = done_q;
    assign frame.bits    = bits_q;
    assign frame.noisy   = noisy_q;
    assign frame.stop_ok = stop_q;
    assign active        = (state_q != ST_WAIT);
    assign idle_hit      = (state_q == ST_WAIT) && (run_q >= thr);
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  rx_frame_t  frame,
    input  logic       nine,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       wake_addr,
    input  logic       idle_hit,
    input  logic       rwu_set,
    input  logic [5:0] clr_mask,
    input  logic       rie,
    input  logic       ilie,
    output logic [7:0] data_q,
    output logic       bit8_q,
    output logic       rdrf_q,
    output logic       ovr_q,
    output logic       nf_q,
    output logic       fe_q,
    output logic       pf_q,
    output logic       idle_q,
    output logic       rwu_q,
    output logic       irq
);
    logic armed_q, hit_q;
    logic addr_bit, ones_odd, par_bad, idle_rise, accept, full;

    assign addr_bit  = nine ? frame.bits[8] : frame.bits[7];
    assign ones_odd  = nine ? ^frame.bits : ^frame.bits[7:0];
    assign par_bad   = par_en && (ones_odd != par_odd);
    assign idle_rise = idle_hit && !hit_q;
    assign accept    = done && (!rwu_q || (wake_addr && addr_bit));
    assign full      = rdrf_q || ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0; bit8_q <= 1'b0; rdrf_q <= 1'b0; ovr_q <= 1'b0;
            nf_q <= 1'b0; fe_q <= 1'b0; pf_q <= 1'b0; idle_q <= 1'b0;
            rwu_q <= 1'b0; armed_q <= 1'b0; hit_q <= 1'b0;
        end else begin
            hit_q <= idle_hit;
            if (clr_mask[0]) rdrf_q <= 1'b0;
            if (clr_mask[1]) ovr_q  <= 1'b0;
            if (clr_mask[2]) nf_q   <= 1'b0;
            if (clr_mask[3]) fe_q   <= 1'b0;
            if (clr_mask[4]) pf_q   <= 1'b0;
            if (clr_mask[5]) idle_q <= 1'b0;
            if (accept) begin
                if (rwu_q) rwu_q <= 1'b0;
                if (full) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q  <= frame.bits[7:0];
                    bit8_q  <= nine & frame.bits[8];
                    rdrf_q  <= 1'b1;
                    armed_q <= 1'b1;
                    if (frame.noisy)    nf_q <= 1'b1;
                    if (!frame.stop_ok) fe_q <= 1'b1;
                    if (par_bad)        pf_q <= 1'b1;
                end
            end
            if (rwu_q) begin
                if (!wake_addr && idle_rise) begin
                    rwu_q   <= 1'b0;
                    armed_q <= 1'b0;
                end
            end else if (idle_hit && armed_q) begin
                idle_q  <= 1'b1;
                armed_q <= 1'b0;
            end
            if (rwu_set) rwu_q <= 1'b1;
        end
    end

    assign irq = (rie & !rwu_q & (rdrf_q | ovr_q)) | (ilie & idle_q);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int RUN_W     = 4,
    parameter int IDLE_BASE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_pin,
    input  logic       tx_int,
    input  logic       tx_pin,
    input  logic       cfg_rx_en,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_idle_after_stop,
    input  logic       cfg_wake_addr,
    input  logic       cfg_rx_inv,
    input  logic       cfg_loop,
    input  logic       cfg_loop_pin,
    input  logic       rwu_set,
    input  logic [5:0] clr_mask,
    input  logic       irq_rx_en,
    input  logic       irq_idle_en,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rdrf,
    output logic       ovr,
    output logic       noise,
    output logic       frame_err,
    output logic       par_err,
    output logic       idle,
    output logic       rwu,
    output logic       rx_active,
    output logic       irq
);
    logic      line;
    logic      done;
    logic      idle_hit;
    rx_frame_t frame;

    rx_line_sel u_sel (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_int(tx_int), .tx_pin(tx_pin),
        .loop_en(cfg_loop), .loop_pin(cfg_loop_pin), .invert(cfg_rx_inv), .line_q(line)
    );

    rx_frame_fsm #(.OVS(OVS), .RUN_W(RUN_W), .IDLE_BASE(IDLE_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(cfg_rx_en), .line(line),
        .nine(cfg_nine), .idle_after_stop(cfg_idle_after_stop), .done(done),
        .frame(frame), .active(rx_active), .idle_hit(idle_hit)
    );

    rx_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .done(done), .frame(frame), .nine(cfg_nine),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd), .wake_addr(cfg_wake_addr),
        .idle_hit(idle_hit), .rwu_set(rwu_set), .clr_mask(clr_mask),
        .rie(irq_rx_en), .ilie(irq_idle_en), .data_q(rx_data), .bit8_q(rx_bit8),
        .rdrf_q(rdrf), .ovr_q(ovr), .nf_q(noise), .fe_q(frame_err), .pf_q(par_err),
        .idle_q(idle), .rwu_q(rwu), .irq(irq)
    );
endmodule

// File: rtl/uart_os_rx_checker.sv
module uart_os_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_data,
    input logic       rdrf,
    input logic       ovr,
    input logic       noise,
    input logic       idle,
    input logic       rwu,
    input logic       rx_active
);
    // R1: the data register changes only on a load that raises rdrf
    p_data_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(rdrf));

    // R3: an overrun leaves the held byte alone
    p_ovr_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_data));

    // R4: noise only rises together with data ready
    p_noise_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise) |-> $rose(rdrf));

    // R8: idle cannot rise out of the sleep state
    p_no_idle_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> !$past(rwu));

    // R6: idle is detected only with no frame in progress
    p_idle_between_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> !$past(rx_active));
endmodule

bind uart_os_rx uart_os_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rdrf(rdrf), .ovr(ovr),
    .noise(noise), .idle(idle), .rwu(rwu), .rx_active(rx_active)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] tcnt = 2'd0;
    logic       os_tick;
    logic       drv = 1'b1;
    int         src_sel = 0;
    logic       inv_drv = 1'b0;
    logic       cfg_rx_en = 1'b1, cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_ias = 1'b0, cfg_wake_addr = 1'b0, cfg_rx_inv = 1'b0;
    logic       cfg_loop = 1'b0, cfg_loop_pin = 1'b0;
    logic       rwu_set = 1'b0, irq_rx_en = 1'b1, irq_idle_en = 1'b1;
    logic [5:0] clr_mask = 6'd0;
    logic       rx_pin, tx_int, tx_pin;
    logic [7:0] rx_data;
    logic       rx_bit8, rdrf, ovr, noise, frame_err, par_err, idle, rwu, rx_active, irq;

    int n_tests = 0, n_fail = 0, irq_bad = 0, cyc = 0;
    logic chk_active = 1'b0;

    always @(negedge clk) tcnt <= tcnt + 2'd1;
    assign os_tick = (tcnt == 2'd0);

    assign rx_pin = (src_sel == 0) ? (drv ^ inv_drv) : 1'b0;
    assign tx_int = (src_sel == 1) ? drv : 1'b0;
    assign tx_pin = (src_sel == 2) ? drv : 1'b0;

    uart_os_rx u_uart_os_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin), .tx_int(tx_int),
        .tx_pin(tx_pin), .cfg_rx_en(cfg_rx_en), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_idle_after_stop(cfg_ias), .cfg_wake_addr(cfg_wake_addr),
        .cfg_rx_inv(cfg_rx_inv), .cfg_loop(cfg_loop), .cfg_loop_pin(cfg_loop_pin),
        .rwu_set(rwu_set), .clr_mask(clr_mask), .irq_rx_en(irq_rx_en), .irq_idle_en(irq_idle_en),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .rdrf(rdrf), .ovr(ovr), .noise(noise),
        .frame_err(frame_err), .par_err(par_err), .idle(idle), .rwu(rwu),
        .rx_active(rx_active), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R12: interrupt model compared on every clock, away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && irq !== ((irq_rx_en & !rwu & (rdrf | ovr)) | (irq_idle_en & idle)))
            irq_bad++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge clk iff tcnt == 2'd3);
    endtask

    // bit 0 start, 1..nd frame bits (LSB first), nd+1 stop; glitch flips offset 7 of one bit
    task automatic send_frame(input logic [8:0] payload, input int nd, input logic stop, input int glitch);
        for (int b = 0; b < nd + 2; b++) begin
            logic v;
            v = (b == 0) ? 1'b0 : (b == nd + 1) ? stop : payload[b-1];
            for (int o = 0; o < 16; o++) begin
                @(negedge clk iff tcnt == 2'd3);
                drv = (b == glitch && o == 7) ? ~v : v;
                if (chk_active && b == 1 && o == 0) check("R11 active mid-frame", 16'(rx_active), 16'd1);
            end
        end
        @(negedge clk iff tcnt == 2'd3);
        drv = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_mask = 6'h3F;
        @(negedge clk); clr_mask = 6'h00;
    endtask

    task automatic pulse_rwu();
        @(negedge clk); rwu_set = 1'b1;
        @(negedge clk); rwu_set = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 reset flags", {8'd0, rdrf, ovr, noise, frame_err, par_err, idle, rwu, irq}, 16'd0);
        check("R1 reset data", {8'd0, rx_data}, 16'd0);
        check("R11 reset active", 16'(rx_active), 16'd0);
        wait_ticks(40);

        // R1 plain 8-bit frame, R11 active during frame, R12 irq
        chk_active = 1'b1;
        send_frame(9'h0A5, 8, 1'b1, -1);
        chk_active = 1'b0;
        check("R1 data A5", {8'd0, rx_data}, 16'h00A5);
        check("R1 rdrf/bit8", {rdrf, rx_bit8, frame_err, par_err, noise}, 16'h10);
        check("R12 irq on ready", 16'(irq), 16'd1);

        // R3 overrun with a noisy frame; R4 noise not set
        send_frame(9'h03C, 8, 1'b1, 3);
        check("R3 ovr set, data held", {ovr, rx_data}, 16'h1A5);
        check("R4 no noise on overrun", 16'(noise), 16'd0);

        clear_all();
        check("R13 clear all", {rdrf, ovr, noise, frame_err, par_err, idle}, 16'd0);

        // R4 noise on a data bit
        send_frame(9'h00F, 8, 1'b1, 4);
        check("R4 noise with data", {noise, rdrf, rx_data}, 16'h30F);
        clear_all();

        // R2 framing error
        send_frame(9'h055, 8, 1'b0, -1);
        check("R2 frame_err", {frame_err, rx_data}, 16'h155);
        wait_ticks(32);
        clear_all();
        wait_ticks(20);

        // R1 nine-bit frame
        cfg_nine = 1'b1;
        send_frame(9'h1C3, 9, 1'b1, -1);
        check("R1 nine-bit", {rx_bit8, rx_data}, 16'h1C3);
        cfg_nine = 1'b0;
        clear_all();

        // R5 parity: 7 bits 0x41 + parity 1 -> three ones
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(9'h0C1, 8, 1'b1, -1);
        check("R5 even parity error", {par_err, rx_data}, 16'h1C1);
        clear_all();
        cfg_par_odd = 1'b1;
        send_frame(9'h0C1, 8, 1'b1, -1);
        check("R5 odd parity ok", 16'(par_err), 16'd0);
        cfg_par_en = 1'b0;
        clear_all();
        wait_ticks(200);
        clear_all();

        // R6 idle from start bit
        cfg_ias = 1'b0;
        send_frame(9'h0FF, 8, 1'b1, -1);
        wait_ticks(48);
        check("R6 early idle", 16'(idle), 16'd1);
        clear_all();
        wait_ticks(200);
        check("R7 no re-set without load", 16'(idle), 16'd0);

        // R6 idle from stop bit
        cfg_ias = 1'b1;
        send_frame(9'h0FF, 8, 1'b1, -1);
        wait_ticks(48);
        check("R6 late idle pending", 16'(idle), 16'd0);
        wait_ticks(176);
        check("R6 late idle set", 16'(idle), 16'd1);
        cfg_ias = 1'b0;
        clear_all();

        // R8/R9 address wakeup
        cfg_wake_addr = 1'b1;
        pulse_rwu();
        check("R8 rwu set", 16'(rwu), 16'd1);
        send_frame(9'h012, 8, 1'b1, -1);
        check("R8 frame discarded", {rdrf, rwu}, 16'h01);
        wait_ticks(200);
        check("R8 no idle asleep", 16'(idle), 16'd0);
        send_frame(9'h085, 8, 1'b1, -1);
        check("R9 address wake", {rwu, rdrf, rx_data}, 16'h0185);
        wait_ticks(200);
        clear_all();

        // R9 idle wakeup
        cfg_wake_addr = 1'b0;
        pulse_rwu();
        wait_ticks(40);
        check("R9 still asleep on old idle", 16'(rwu), 16'd1);
        send_frame(9'h000, 8, 1'b1, -1);
        check("R8 frame ignored", 16'(rdrf), 16'd0);
        wait_ticks(200);
        check("R9 idle wake", {rwu, idle}, 16'd0);

        // R10 loopback sources and inversion
        cfg_loop = 1'b1; cfg_loop_pin = 1'b0; src_sel = 1;
        wait_ticks(20);
        send_frame(9'h06E, 8, 1'b1, -1);
        check("R10 loop internal", {rdrf, rx_data}, 16'h16E);
        clear_all();
        cfg_loop_pin = 1'b1; src_sel = 2;
        wait_ticks(20);
        send_frame(9'h091, 8, 1'b1, -1);
        check("R10 loop tx pin", {rdrf, rx_data}, 16'h191);
        clear_all();
        @(negedge clk);
        cfg_loop = 1'b0; src_sel = 0; inv_drv = 1'b1; cfg_rx_inv = 1'b1;
        wait_ticks(20);
        send_frame(9'h033, 8, 1'b1, -1);
        check("R10 inverted pin", {rdrf, rx_data}, 16'h133);
        clear_all();
        @(negedge clk);
        inv_drv = 1'b0; cfg_rx_inv = 1'b0;
        wait_ticks(200);
        clear_all();

        // R11 false start: low for 6 ticks only
        drv = 1'b0;
        wait_ticks(6);
        drv = 1'b1;
        wait_ticks(40);
        check("R11 false start dropped", {rdrf, frame_err, noise, rx_active}, 16'd0);

        // R13 receiver disabled
        cfg_rx_en = 1'b0;
        send_frame(9'h0AA, 8, 1'b1, -1);
        check("R13 disabled no frame", {rdrf, rx_data}, 16'h033);

        check("R12 irq every cycle", 16'(irq_bad), 16'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule